// File: doc/BRIEF.md
# Register-Reference Accumulator Operation Unit

This unit carries out the accumulator and carry-flag instructions that have no memory operand. It becomes active in one execution step: the opcode is 7, the addressing-mode bit is 0, the step counter reads 3, and the machine is running. In that step it reads the 12-bit operand field of the instruction and works out the next accumulator value and the next carry (E) flag. It raises a program-counter increment when a skip condition is met, a halt strobe for the halt instruction, and a sequence-counter clear. The surrounding processor loads the next values into its accumulator and E flag on the clock edge that ends the step.

Each instruction is a single set bit of the operand field. The two rotates treat E and the accumulator as one 17-bit ring. The unit also holds the start flag. Reset sets this flag and the halt instruction clears it. While the flag is clear the unit stays inactive until the next reset.

Top module: `rr_accum_unit`

## Requirements
- R1: Outside the execution step (opcode not 7, mode bit 1, step not 3, or start flag clear), acNext equals acIn, eNext equals eIn, and pcInc, haltStrobe and scClear are all 0.
- R2: In the execution step scClear is 1, whatever the operand field holds, including an all-zero field.
- R3: Field bit 11 (word 7800) gives acNext = 0. Field bit 10 (word 7400) gives eNext = 0. Each leaves the other register unchanged.
- R4: Field bit 9 (7200) gives acNext = bitwise complement of acIn (A937 becomes 56C8). Field bit 8 (7100) inverts E.
- R5: Field bit 7 (7080) rotates the 17-bit ring {E, AC} right: acNext = {eIn, acIn[15:1]}, eNext = acIn[0] (A937 with E=1 gives D49B, E=1). Field bit 6 (7040) rotates it left: acNext = {acIn[14:0], eIn}, eNext = acIn[15] (A937 with E=1 gives 526F, E=1).
- R6: Field bit 5 (7020) gives acNext = acIn + 1 modulo 2^16 (FFFF wraps to 0000) and leaves E unchanged.
- R7: pcInc is 1 in these cases: field bit 4 (7010) when acIn[15] is 0, which includes AC = 0; field bit 3 (7008) when acIn[15] is 1; field bit 2 (7004) when acIn is 0; field bit 1 (7002) when eIn is 0. These skip instructions leave AC and E unchanged.
- R8: Field bit 0 (7001) raises haltStrobe in that step. The start flag (output running) goes to 0 at the following clock edge and stays 0. After that the unit behaves as in R1.
- R9: When more than one field bit is set, only the highest-numbered set bit takes effect and the lower ones are ignored.
- R10: After reset the start flag (running) is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| opCode | input | 3 | Decoded opcode field of the instruction |
| modeBit | input | 1 | Addressing-mode bit of the instruction |
| stepCount | input | 4 | Current timing step of the sequence counter |
| irField | input | 12 | Operand field of the instruction, one bit per operation |
| acIn | input | 16 | Present accumulator value |
| eIn | input | 1 | Present carry flag |
| acNext | output | 16 | Accumulator value to load at the end of the step |
| eNext | output | 1 | Carry flag value to load at the end of the step |
| pcInc | output | 1 | Increment the program counter (skip) |
| haltStrobe | output | 1 | Halt request; clears the start flag |
| scClear | output | 1 | Clear the sequence counter |
| running | output | 1 | Start flag |

## Verification
Outside the start flag, every result is combinational, so a wrong decode or a wrong priority pick shows on acNext, eNext or pcInc in the same cycle that the instruction is presented. Each cycle is compared against a behavioural model of the 17-bit ring. A start flag that fails to clear or to stay cleared shows one edge after the halt step: running is wrong and a later execution step still produces a scClear. A wrong reset value shows on running straight after reset.

// File: rtl/rr_pkg.sv
package rr_pkg;
  localparam int FIELD_W = 12;

  // operand-field bit positions; the position is also the priority
  localparam int B_CLR_AC  = 11;
  localparam int B_CLR_E   = 10;
  localparam int B_CMP_AC  = 9;
  localparam int B_CMP_E   = 8;
  localparam int B_ROT_R   = 7;
  localparam int B_ROT_L   = 6;
  localparam int B_INC_AC  = 5;
  localparam int B_SK_POS  = 4;
  localparam int B_SK_NEG  = 3;
  localparam int B_SK_ZERO = 2;
  localparam int B_SK_EZ   = 1;
  localparam int B_HALT    = 0;

  typedef struct packed {
    logic active;
    logic clrAc;
    logic clrE;
    logic cmpAc;
    logic cmpE;
    logic rotR;
    logic rotL;
    logic incAc;
    logic skPos;
    logic skNeg;
    logic skZero;
    logic skEZero;
    logic halt;
  } rrStrobes_t;
endpackage

// File: rtl/rr_control.sv
module rr_control
  import rr_pkg::*;
#(
  parameter int STEP_W    = 4,
  parameter int OPCODE_W  = 3,
  parameter int RR_OPCODE = 7,
  parameter int EXEC_STEP = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [OPCODE_W-1:0] opCode,
  input  logic                modeBit,
  input  logic [STEP_W-1:0]   stepCount,
  input  logic [FIELD_W-1:0]  irField,
  output rrStrobes_t          strobes,
  output logic                running
);
  localparam logic [OPCODE_W-1:0] OP_MATCH   = OPCODE_W'(RR_OPCODE);
  localparam logic [STEP_W-1:0]   STEP_MATCH = STEP_W'(EXEC_STEP);

  logic               inStep;
  logic [FIELD_W-1:0] pick;
  logic               runFlag;

  assign inStep = (opCode == OP_MATCH) && !modeBit &&
                  (stepCount == STEP_MATCH) && runFlag;

  // keep only the highest-numbered set bit
  always_comb begin
    pick = '0;
    for (int i = 0; i < FIELD_W; i++) begin
      if (irField[i]) begin
        pick    = '0;
        pick[i] = 1'b1;
      end
    end
  end

  always_comb begin
    strobes         = '0;
    strobes.active  = inStep;
    strobes.clrAc   = inStep & pick[B_CLR_AC];
    strobes.clrE    = inStep & pick[B_CLR_E];
    strobes.cmpAc   = inStep & pick[B_CMP_AC];
    strobes.cmpE    = inStep & pick[B_CMP_E];
    strobes.rotR    = inStep & pick[B_ROT_R];
    strobes.rotL    = inStep & pick[B_ROT_L];
    strobes.incAc   = inStep & pick[B_INC_AC];
    strobes.skPos   = inStep & pick[B_SK_POS];
    strobes.skNeg   = inStep & pick[B_SK_NEG];
    strobes.skZero  = inStep & pick[B_SK_ZERO];
    strobes.skEZero = inStep & pick[B_SK_EZ];
    strobes.halt    = inStep & pick[B_HALT];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             runFlag <= 1'b1;
    else if (strobes.halt) runFlag <= 1'b0;
  end

  assign running = runFlag;
endmodule

// File: rtl/rr_datapath.sv
module rr_datapath
  import rr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  rrStrobes_t        strobes,
  input  logic [DATA_W-1:0] acIn,
  input  logic              eIn,
  output logic [DATA_W-1:0] acNext,
  output logic              eNext,
  output logic              pcInc,
  output logic              haltStrobe,
  output logic              scClear
);
  localparam int RING_W = DATA_W + 1;

  logic [RING_W-1:0] ring;
  logic [RING_W-1:0] ringRight;
  logic [RING_W-1:0] ringLeft;
  logic              acSign;
  logic              acZero;

  assign ring      = {eIn, acIn};
  assign ringRight = {ring[0], ring[RING_W-1:1]};
  assign ringLeft  = {ring[RING_W-2:0], ring[RING_W-1]};
  assign acSign    = acIn[DATA_W-1];
  assign acZero    = (acIn == '0);

  always_comb begin
    acNext = acIn;
    eNext  = eIn;
    if (strobes.clrAc) acNext = '0;
    if (strobes.clrE)  eNext  = 1'b0;
    if (strobes.cmpAc) acNext = ~acIn;
    if (strobes.cmpE)  eNext  = ~eIn;
    if (strobes.rotR) begin
      acNext = ringRight[DATA_W-1:0];
      eNext  = ringRight[RING_W-1];
    end
    if (strobes.rotL) begin
      acNext = ringLeft[DATA_W-1:0];
      eNext  = ringLeft[RING_W-1];
    end
    if (strobes.incAc) acNext = acIn + DATA_W'(1);
  end

  assign pcInc = (strobes.skPos & ~acSign) | (strobes.skNeg & acSign) |
                 (strobes.skZero & acZero) | (strobes.skEZero & ~eIn);
  assign haltStrobe = strobes.halt;
  assign scClear    = strobes.active;
endmodule

// File: rtl/rr_accum_unit.sv
module rr_accum_unit
  import rr_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int STEP_W    = 4,
  parameter int OPCODE_W  = 3,
  parameter int RR_OPCODE = 7,
  parameter int EXEC_STEP = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [OPCODE_W-1:0] opCode,
  input  logic                modeBit,
  input  logic [STEP_W-1:0]   stepCount,
  input  logic [11:0]         irField,
  input  logic [DATA_W-1:0]   acIn,
  input  logic                eIn,
  output logic [DATA_W-1:0]   acNext,
  output logic                eNext,
  output logic                pcInc,
  output logic                haltStrobe,
  output logic                scClear,
  output logic                running
);
  rrStrobes_t strobes;

  rr_control #(
    .STEP_W(STEP_W), .OPCODE_W(OPCODE_W),
    .RR_OPCODE(RR_OPCODE), .EXEC_STEP(EXEC_STEP)
  ) u_control (
    .clk(clk), .rstN(rstN), .opCode(opCode), .modeBit(modeBit),
    .stepCount(stepCount), .irField(irField),
    .strobes(strobes), .running(running)
  );

  rr_datapath #(.DATA_W(DATA_W)) u_datapath (
    .strobes(strobes), .acIn(acIn), .eIn(eIn),
    .acNext(acNext), .eNext(eNext), .pcInc(pcInc),
    .haltStrobe(haltStrobe), .scClear(scClear)
  );
endmodule

// File: rtl/rr_accum_unit_chk.sv
module rr_accum_unit_chk #(
  parameter int DATA_W    = 16,
  parameter int STEP_W    = 4,
  parameter int OPCODE_W  = 3,
  parameter int RR_OPCODE = 7,
  parameter int EXEC_STEP = 3
) (
  input logic                clk,
  input logic                rstN,
  input logic [OPCODE_W-1:0] opCode,
  input logic                modeBit,
  input logic [STEP_W-1:0]   stepCount,
  input logic [11:0]         irField,
  input logic [DATA_W-1:0]   acIn,
  input logic                eIn,
  input logic [DATA_W-1:0]   acNext,
  input logic                eNext,
  input logic                pcInc,
  input logic                haltStrobe,
  input logic                scClear,
  input logic                running
);
  logic outOfStep;
  assign outOfStep = (opCode != OPCODE_W'(RR_OPCODE)) || modeBit ||
                     (stepCount != STEP_W'(EXEC_STEP));

  a_r1_quiet: assert property (@(posedge clk) disable iff (!rstN)
    outOfStep |-> (!scClear && !pcInc && !haltStrobe &&
                   acNext == acIn && eNext == eIn));

  a_r2_sc_clear: assert property (@(posedge clk) disable iff (!rstN)
    (!outOfStep && running) |-> scClear);

  a_r6_inc_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (scClear && irField == 12'h020) |->
      (acNext == DATA_W'(acIn + DATA_W'(1)) && eNext == eIn));

  a_r7_skip_in_step: assert property (@(posedge clk) disable iff (!rstN)
    pcInc |-> scClear);

  a_r8_halt_stops: assert property (@(posedge clk) disable iff (!rstN)
    haltStrobe |=> !running);

  a_r8_stays_halted: assert property (@(posedge clk) disable iff (!rstN)
    !running |=> (!running && !scClear));
endmodule

bind rr_accum_unit rr_accum_unit_chk #(
  .DATA_W(DATA_W), .STEP_W(STEP_W), .OPCODE_W(OPCODE_W),
  .RR_OPCODE(RR_OPCODE), .EXEC_STEP(EXEC_STEP)
) u_chk (.*);

// File: tb/rr_accum_unit_bench.sv
module rr_accum_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  opCode = '0;
  logic        modeBit = 1'b0;
  logic [3:0]  stepCount = '0;
  logic [11:0] irField = '0;
  logic [15:0] acIn = '0;
  logic        eIn = 1'b0;
  logic [15:0] acNext;
  logic        eNext, pcInc, haltStrobe, scClear, running;

  int total = 0;
  int bad = 0;
  bit modelRun = 1'b1;

  always #10 clk = ~clk;

  rr_accum_unit u_rr_accum_unit (
    .clk(clk), .rstN(rstN), .opCode(opCode), .modeBit(modeBit),
    .stepCount(stepCount), .irField(irField), .acIn(acIn), .eIn(eIn),
    .acNext(acNext), .eNext(eNext), .pcInc(pcInc),
    .haltStrobe(haltStrobe), .scClear(scClear), .running(running)
  );

  // behavioural reference on a 17-bit integer ring
  task automatic model(output logic [15:0] xAc, output logic xE,
                       output logic xPc, output logic xHalt, output logic xSc);
    int ring = int'(eIn) * 65536 + int'(acIn);
    int topBit = -1;
    xAc = acIn; xE = eIn; xPc = 0; xHalt = 0; xSc = 0;
    if (opCode == 3'd7 && !modeBit && stepCount == 4'd3 && modelRun) begin
      xSc = 1;
      for (int i = 0; i < 12; i++) if (irField[i]) topBit = i;
      case (topBit)
        11: xAc = 16'h0000;
        10: xE = 1'b0;
        9:  xAc = 16'(65535 - int'(acIn));
        8:  xE = !eIn;
        7:  begin xAc = 16'(ring / 2); xE = 1'(ring % 2); end
        6:  begin xAc = 16'((ring * 2) % 65536 + ring / 65536); xE = 1'((ring / 32768) % 2); end
        5:  xAc = 16'((int'(acIn) + 1) % 65536);
        4:  xPc = (acIn < 16'h8000);
        3:  xPc = (acIn >= 16'h8000);
        2:  xPc = (acIn == 16'h0000);
        1:  xPc = (eIn == 1'b0);
        0:  xHalt = 1;
        default: ;
      endcase
    end
  endtask

  task automatic compare(string tag);
    logic [15:0] xAc; logic xE, xPc, xHalt, xSc;
    model(xAc, xE, xPc, xHalt, xSc);
    total++;
    if (acNext !== xAc || eNext !== xE || pcInc !== xPc ||
        haltStrobe !== xHalt || scClear !== xSc || running !== modelRun) begin
      bad++;
      $display("FAIL %s: got ac=%h e=%b pc=%b halt=%b sc=%b run=%b exp ac=%h e=%b pc=%b halt=%b sc=%b run=%b",
               tag, acNext, eNext, pcInc, haltStrobe, scClear, running,
               xAc, xE, xPc, xHalt, xSc, modelRun);
    end
  endtask

  // drive after the falling edge, compare before the rising edge, then advance model state
  task automatic cycle(string tag, input logic [2:0] op, input logic m,
                       input logic [3:0] st, input logic [11:0] f,
                       input logic [15:0] ac, input logic e);
    @(negedge clk);
    opCode = op; modeBit = m; stepCount = st; irField = f; acIn = ac; eIn = e;
    #5;
    compare(tag);
    if (opCode == 3'd7 && !modeBit && stepCount == 4'd3 && modelRun && irField != 0) begin
      int tb = 0;
      for (int i = 0; i < 12; i++) if (irField[i]) tb = i;
      if (tb == 0) modelRun = 0;
    end
  endtask

  function automatic string tagOf(input logic [11:0] f);
    int tb = -1;
    for (int i = 0; i < 12; i++) if (f[i]) tb = i;
    case (tb)
      11, 10: return "R3";
      9, 8:   return "R4";
      7, 6:   return "R5";
      5:      return "R6";
      4, 3, 2, 1: return "R7";
      0:      return "R8";
      default: return "R2";
    endcase
  endfunction

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog: got hung expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    cycle("R10 reset state", 3'd0, 0, 4'd0, 12'h000, 16'h0000, 0);
    // worked table from A937, E=1
    for (int k = 0; k < 12; k++) begin
      logic [11:0] f = 12'h800 >> k;
      if (f != 12'h001) cycle(tagOf(f), 3'd7, 0, 4'd3, f, 16'hA937, 1);
    end
    cycle("R7 spa on zero", 3'd7, 0, 4'd3, 12'h010, 16'h0000, 1);
    cycle("R7 sza on zero", 3'd7, 0, 4'd3, 12'h004, 16'h0000, 0);
    cycle("R7 sze e=0", 3'd7, 0, 4'd3, 12'h002, 16'h1234, 0);
    cycle("R6 inc wrap", 3'd7, 0, 4'd3, 12'h020, 16'hFFFF, 0);
    cycle("R5 cir e=0", 3'd7, 0, 4'd3, 12'h080, 16'h0001, 0);
    cycle("R5 cil e=0", 3'd7, 0, 4'd3, 12'h040, 16'h8000, 0);
    cycle("R2 empty field", 3'd7, 0, 4'd3, 12'h000, 16'h5555, 1);
    cycle("R9 cla over inc", 3'd7, 0, 4'd3, 12'h820, 16'h1234, 1);
    cycle("R9 cma over skips", 3'd7, 0, 4'd3, 12'h21E, 16'h0000, 0);
    cycle("R1 wrong step", 3'd7, 0, 4'd4, 12'h800, 16'h1234, 1);
    cycle("R1 mode bit", 3'd7, 1, 4'd3, 12'h800, 16'h1234, 1);
    cycle("R1 wrong opcode", 3'd6, 0, 4'd3, 12'h800, 16'h1234, 1);
    for (int n = 0; n < 400; n++) begin
      logic [11:0] f = 12'($urandom) & 12'hFFE;
      logic [2:0] op = ($urandom % 4 == 0) ? 3'($urandom) : 3'd7;
      logic [3:0] st = ($urandom % 4 == 0) ? 4'($urandom) : 4'd3;
      cycle(tagOf(f), op, 1'($urandom % 8 == 0), st, f, 16'($urandom), 1'($urandom));
    end
    cycle("R8 halt step", 3'd7, 0, 4'd3, 12'h001, 16'h0F0F, 0);
    cycle("R8 halted ignores cla", 3'd7, 0, 4'd3, 12'h800, 16'h0F0F, 0);
    cycle("R8 halted ignores skip", 3'd7, 0, 4'd3, 12'h008, 16'h8000, 0);
    @(negedge clk); rstN = 1'b0; modelRun = 1'b1;
    @(negedge clk); rstN = 1'b1;
    cycle("R10 after reset", 3'd7, 0, 4'd3, 12'h100, 16'h0000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule